// File: doc/BRIEF.md
# Receive FIFO Trigger-and-Timeout Interrupt

This block raises the receive interrupt of a serial port. It follows how full the receive FIFO is from two strobes: one marks a byte written into the FIFO by the bit-level receiver, the other marks a byte taken out by the host. It sets a data-ready flag in two cases. The first is when the fill count reaches a programmable trigger level. The second is when input stops for fifteen elementary time units (ETU) while the FIFO holds fewer bytes than the trigger. The second case means that a short burst, such as a few characters typed at a console, still reaches the host without waiting for the FIFO to fill.

The block makes the ETU tick itself by dividing the system clock. The default division gives one bit time at 9600 bit/s. The host clears the data-ready flag with a strobe. The interrupt line is the flag gated by a receive-interrupt enable. The FIFO storage and the bit-level receiver live outside this block.

Top module: `rx_trig_irq`

## Requirements
- R1: After reset the data-ready flag and the interrupt are low, and the fill count is zero.
- R2: The fill count goes up on each accepted byte strobe and down on each read strobe. A read strobe while the count is zero is ignored. A byte strobe while the count equals DEPTH is ignored unless a read is accepted in the same cycle.
- R3: While the fill count is greater than or equal to the effective trigger, the flag is high from the next cycle on. A trigger value of 0 is taken as 1.
- R4: `irq_o` is high exactly when the flag is high and `rie_i` is 1. The flag sets whatever the value of `rie_i`.
- R5: A byte that leaves the count below the effective trigger arms the idle timeout. If nothing else disturbs it, the flag goes high exactly 15·ETU_DIV clock cycles after the edge that accepted that byte.
- R6: Each later byte that still leaves the count below the trigger restarts the 15-ETU timeout from its own edge.
- R7: A byte that brings the count up to the trigger cancels any pending timeout. The timeout does not set the flag afterwards, even after the count falls again.
- R8: Read strobes do not restart a pending timeout. A read that empties the FIFO cancels it.
- R9: `clr_i` drops the flag on the next edge, unless a trigger or timeout set condition is present in the same cycle. A set condition wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_vld_i | input | 1 | A received byte is written into the FIFO |
| rd_i | input | 1 | The host takes one byte out of the FIFO |
| clr_i | input | 1 | The host clears the data-ready flag |
| rie_i | input | 1 | Receive interrupt enable |
| trig_lvl_i | input | $clog2(DEPTH+1) | Trigger fill level; 0 acts as 1 |
| rdy_o | output | 1 | Data-ready flag |
| irq_o | output | 1 | Level receive interrupt |

## Verification
The bench checks the exact cycle on which the timeout fires. A timer that is off by one tick, or that counts from a free-running divider phase, moves that edge and is caught. It also sends a second byte partway through a pending timeout, and does reads in the middle of one. A design that fails to reload on the byte, or that reloads on the read, fires at the wrong time. It reaches the trigger and then drains below it without emptying the FIFO, which exposes a timeout that survives cancellation. Reads on an empty FIFO and writes to a full one would shift the count, so a trigger that is crossed too early or too late shows the fault. A clear issued while the count still meets the trigger has to leave the flag set.

// File: rtl/rx_irq_pkg.sv
package rx_irq_pkg;
  localparam int TMO_ETUS = 15;
  localparam int TW       = $clog2(TMO_ETUS + 1);
  typedef logic [TW-1:0] tmr_t;

  function automatic int etu_div(input longint clk_hz, input longint baud);
    return int'((clk_hz + baud / 2) / baud);
  endfunction
endpackage

// File: rtl/rx_etu_tick.sv
module rx_etu_tick #(
  parameter int ETU_DIV = 26042
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int DW = (ETU_DIV > 1) ? $clog2(ETU_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(ETU_DIV - 1);

  logic [DW-1:0] div_q;

  assign tick_o = (div_q == LAST) && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             div_q <= '0;
    else if (restart_i)      div_q <= '0;
    else if (div_q == LAST)  div_q <= '0;
    else                     div_q <= div_q + 1'b1;
  end

  AST_DIV_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_q <= LAST); // R5
endmodule

// File: rtl/rx_fill_cnt.sv
module rx_fill_cnt #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          byte_vld_i,
  input  logic          rd_i,
  output logic          push_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_nxt_o
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [CW-1:0] cnt_q;
  logic          pop;

  assign pop       = rd_i && (cnt_q != '0);
  assign push_o    = byte_vld_i && ((cnt_q != FULL) || pop);
  assign cnt_nxt_o = cnt_q + CW'(push_o) - CW'(pop);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt_o;
  end

  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == FULL) && byte_vld_i && !rd_i |=> cnt_q == FULL); // R2
  AST_EMPTY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) && rd_i && !byte_vld_i |=> cnt_q == '0); // R2
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL); // R2
endmodule

// File: rtl/rx_idle_tmr.sv
module rx_idle_tmr
  import rx_irq_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [CW-1:0] cnt_nxt_i,
  input  logic [CW-1:0] eff_trig_i,
  input  logic          tick_i,
  output logic          fire_o
);
  tmr_t tmr_q;
  logic act_q;

  assign fire_o = act_q && tick_i && (tmr_q == TW'(1)) && !push_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q <= '0;
      act_q <= 1'b0;
    end else if (push_i) begin
      if (cnt_nxt_i < eff_trig_i) begin
        tmr_q <= TW'(TMO_ETUS);
        act_q <= 1'b1;
      end else begin
        act_q <= 1'b0;
      end
    end else if (cnt_nxt_i == '0) begin
      act_q <= 1'b0;
    end else if (fire_o) begin
      act_q <= 1'b0;
    end else if (act_q && tick_i) begin
      tmr_q <= tmr_q - 1'b1;
    end
  end

  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && (cnt_nxt_i < eff_trig_i) |=> act_q && (tmr_q == TW'(TMO_ETUS))); // R6
  AST_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && (cnt_nxt_i >= eff_trig_i) |=> !act_q); // R7
  AST_EMPTY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !push_i && (cnt_nxt_i == '0) |=> !act_q); // R8
  AST_FIRE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !act_q); // R5
endmodule

// File: rtl/rx_trig_irq.sv
module rx_trig_irq
  import rx_irq_pkg::*;
#(
  parameter int     DEPTH   = 16,
  parameter longint CLK_HZ  = 250_000_000,
  parameter longint BAUD    = 9600,
  localparam int    CW      = $clog2(DEPTH + 1),
  localparam int    ETU_DIV = etu_div(CLK_HZ, BAUD)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          byte_vld_i,
  input  logic          rd_i,
  input  logic          clr_i,
  input  logic          rie_i,
  input  logic [CW-1:0] trig_lvl_i,
  output logic          rdy_o,
  output logic          irq_o
);
  logic          push, tick, fire, hit, rdy_q;
  logic [CW-1:0] cnt, cnt_nxt, eff_trig;

  assign eff_trig = (trig_lvl_i == '0) ? CW'(1) : trig_lvl_i;
  assign hit      = cnt >= eff_trig;

  rx_fill_cnt #(.DEPTH(DEPTH)) u_fill (
    .clk_i, .rst_ni, .byte_vld_i, .rd_i,
    .push_o(push), .cnt_o(cnt), .cnt_nxt_o(cnt_nxt)
  );

  rx_etu_tick #(.ETU_DIV(ETU_DIV)) u_tick (
    .clk_i, .rst_ni, .restart_i(push), .tick_o(tick)
  );

  rx_idle_tmr #(.CW(CW)) u_tmr (
    .clk_i, .rst_ni, .push_i(push), .cnt_nxt_i(cnt_nxt),
    .eff_trig_i(eff_trig), .tick_i(tick), .fire_o(fire)
  );

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_q <= 1'b0;
    else         rdy_q <= (rdy_q && !clr_i) || hit || fire;
  end

  assign rdy_o = rdy_q;
  assign irq_o = rdy_q && rie_i;

  AST_TRIG_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> rdy_o); // R3
  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !hit && !fire |=> !rdy_o); // R9
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o && !clr_i |=> rdy_o); // R9
  AST_FIRE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> rdy_o); // R5
endmodule

// File: tb/sim_rx_trig_irq.sv
module sim_rx_trig_irq;
  localparam int DEPTH = 8;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int DIV   = 4;
  localparam int TMO   = 15 * DIV;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vld = 1'b0, rd = 1'b0, clr = 1'b0, rie = 1'b0;
  logic [CW-1:0] trig = '0;
  logic rdy, irq;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  // reference model state
  int     m_cnt = 0;
  bit     m_rdy = 1'b0;
  longint m_dl = -1, cyc = 0;

  always #2 clk = ~clk;

  rx_trig_irq #(.DEPTH(DEPTH), .CLK_HZ(40), .BAUD(10)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .byte_vld_i(vld), .rd_i(rd), .clr_i(clr),
    .rie_i(rie), .trig_lvl_i(trig), .rdy_o(rdy), .irq_o(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_rdy = 1'b0; m_dl = -1; cyc = 0;
    end else begin
      int eff, nc;
      bit hit, pop, push, fire;
      eff  = (trig == 0) ? 1 : int'(trig);
      hit  = m_cnt >= eff;
      pop  = rd && m_cnt > 0;
      push = vld && (m_cnt < DEPTH || pop);
      fire = !push && (m_dl == cyc);
      nc   = m_cnt + int'(push) - int'(pop);
      m_rdy = (m_rdy && !clr) || hit || fire;
      if (push)        m_dl = (nc < eff) ? cyc + TMO : -1;
      else if (nc == 0) m_dl = -1;
      else if (fire)    m_dl = -1;
      m_cnt = nc;
      cyc++;
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock model comparison
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(rdy, m_rdy, "R3/R5/R9 rdy vs model");
      chk(irq, m_rdy && rie, "R4 irq vs model");
    end
  end

  task automatic drive(input logic v, input logic r, input logic c, input int n);
    @(negedge clk); vld = v; rd = r; clr = c;
    repeat (n) @(negedge clk);
    vld = 1'b0; rd = 1'b0; clr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic see(input logic exp_rdy, input logic exp_irq, input string tag);
    #1;
    chk(rdy, exp_rdy, tag);
    chk(irq, exp_irq, tag);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    see(1'b0, 1'b0, "R1 reset state");
    rst_n = 1'b1;
    idle(2);
    see(1'b0, 1'b0, "R1 after reset release");

    // trigger path
    trig = CW'(4); rie = 1'b1;
    drive(1, 0, 0, 4); idle(2);
    see(1'b1, 1'b1, "R3 trigger reached");
    drive(0, 0, 1, 1); idle(1);
    see(1'b1, 1'b1, "R9 clear loses to trigger");
    drive(0, 1, 1, 4); idle(2);
    see(1'b0, 1'b0, "R9 clear after drain");
    idle(80);
    see(1'b0, 1'b0, "R8 empty leaves timer idle");

    // timeout below trigger
    drive(1, 0, 0, 1); idle(50);
    see(1'b0, 1'b0, "R5 no early timeout");
    idle(15);
    see(1'b1, 1'b1, "R5 timeout fires");

    // restart on later byte, masked irq
    drive(0, 0, 1, 1); rie = 1'b0;
    drive(1, 0, 0, 1); idle(30);
    drive(1, 0, 0, 1); idle(45);
    see(1'b0, 1'b0, "R6 second byte restarts timeout");
    idle(20);
    see(1'b1, 1'b0, "R4 flag sets with irq masked");
    rie = 1'b1; #1;
    chk(irq, 1'b1, "R4 unmask shows irq");

    // reads do not restart
    trig = CW'(8);
    drive(0, 0, 1, 1);
    drive(1, 0, 0, 1); idle(20);
    drive(0, 1, 0, 1); idle(30);
    see(1'b0, 1'b0, "R8 read mid-timeout no early set");
    idle(15);
    see(1'b1, 1'b1, "R8 read did not restart timeout");

    // cancellation on reaching trigger
    drive(0, 1, 1, 4); idle(2);
    see(1'b0, 1'b0, "R9 cleared before cancel test");
    trig = CW'(3);
    drive(1, 0, 0, 3); idle(2);
    see(1'b1, 1'b1, "R3 trigger of three");
    drive(0, 1, 0, 1);
    drive(0, 0, 1, 1); idle(80);
    see(1'b0, 1'b0, "R7 cancelled timeout stays silent");
    drive(0, 1, 0, 2); idle(2);

    // trigger zero acts as one
    trig = '0;
    drive(1, 0, 0, 1); idle(2);
    see(1'b1, 1'b1, "R3 zero trigger as one");
    drive(0, 1, 1, 1); idle(1);
    drive(0, 0, 1, 1); idle(2);
    see(1'b0, 1'b0, "R9 clear after zero trigger");

    // full and empty boundaries
    trig = CW'(8);
    drive(1, 0, 0, 10); idle(2);
    see(1'b1, 1'b1, "R3 full fifo meets trigger");
    drive(1, 1, 0, 3);
    drive(0, 1, 1, 8);
    drive(0, 1, 0, 1);
    drive(0, 0, 1, 1); idle(2);
    see(1'b0, 1'b0, "R2 drained and empty");
    drive(1, 0, 0, 7); idle(2);
    see(1'b0, 1'b0, "R2 seven below trigger of eight");
    drive(1, 0, 0, 1); idle(2);
    see(1'b1, 1'b1, "R2 eighth byte hits trigger");
    drive(0, 1, 1, 8); idle(2);

    // mixed traffic against model
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      vld = (((i / 150) % 2) == 0) && ($urandom_range(99) < 35);
      rd  = $urandom_range(99) < 20;
      clr = $urandom_range(99) < 8;
      if ($urandom_range(99) < 3) rie = ~rie;
      if ($urandom_range(999) < 5) trig = CW'($urandom_range(DEPTH));
    end
    drive(0, 0, 0, 1); idle(4);
    finish_run();
  end
endmodule